// File: doc/BRIEF.md
# Serial Addressed Port Frame Controller

This block is the serial front end of an 8-bit addressable I/O expander. A host reaches it over a four-wire synchronous serial link with an active-low enable. In each frame the host sends a header byte and then one or more data bytes, most significant bit first. The two top header bits carry a device address. Only the device whose strapped address matches takes part in the rest of the frame, so four devices can share a single enable line. The header also chooses between the data and direction registers, chooses read or write, and carries a two-bit write format and a two-bit compare mode. Both 2-bit fields go to the register file unchanged.

The serial inputs are synchronised to a faster system clock. The SCK level seen when the enable falls is taken as the idle level for the whole frame. The edge that leaves the idle level launches the next MISO bit, and the edge that returns to idle samples MOSI. MISO is reported as a value plus an output-enable, and a low enable stands for high impedance.

The register file and the compare logic sit outside this block. The block reads a register through `rd_sel` and `rd_data`, and it takes a copy of `rd_data` when a byte boundary is reached. A write leaves as a single-cycle `wr_valid` pulse with `wr_data`. The target and format come from the `ctrl_*` outputs, which hold their values until the next matching header. There is no ready signal on the write side, because a serial master cannot be stalled. The register file must therefore accept `wr_valid` in the cycle it appears. `ctrl_valid` likewise has no back-pressure.

Top module: `spf_port_ctrl`

## Requirements
- R1: After reset, and within SYNC_STAGES+2 system clocks of the enable going high, `miso_oe` is 0.
- R2: The SCK level at the enable falling edge is the idle level. Bits are launched on the edge away from idle and sampled on the edge back to idle. Both idle levels work.
- R3: Header bits 7:6 are compared with `id_strap[1:0]` (bit 7 against `id_strap[1]`). On a mismatch `miso_oe` stays 0 for the whole frame and no `ctrl_valid` or `wr_valid` is issued.
- R4: During the header, bit slots 0 to 2 are not driven. Slots 3 to 6 drive header bits 7, 6, 5 and 4. Slot 7 drives `cmp_flag` as it was latched at the enable falling edge.
- R5: After the eighth header bit of a matching frame, `ctrl_valid` pulses once. At the same time `ctrl_sel`=bit 5 (1 selects the direction register), `ctrl_rw`=bit 4 (1 = write), `ctrl_fmt`=bits 3:2 and `ctrl_cmp`=bits 1:0.
- R6: In a read (bit 4 = 0), the register chosen by bit 5 (`rd_sel`) is shifted out MSB first during the first data byte.
- R7: In a read, every further data byte shifts out a fresh copy of the selected register, for as long as the enable stays low.
- R8: In a write (bit 4 = 1), the old register value is shifted out while the new byte is shifted in. After the eighth data bit, a single `wr_valid` pulse carries the received byte on `wr_data`.
- R9: After a write byte, `miso_oe` returns to 0 and further bytes in the same frame produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame enable (asynchronous) |
| sck | input | 1 | Serial clock (asynchronous) |
| mosi | input | 1 | Serial data from the host |
| id_strap | input | 2 | Strapped device address |
| cmp_flag | input | 1 | Compare result from the register file |
| rd_data | input | 8 | Value of the register chosen by rd_sel |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | MISO drive enable (0 = high impedance) |
| rd_sel | output | 1 | Register chosen for readback (1 = direction) |
| ctrl_valid | output | 1 | Header accepted pulse |
| ctrl_sel | output | 1 | Register select from the header |
| ctrl_rw | output | 1 | Read/write from the header (1 = write) |
| ctrl_fmt | output | 2 | Write format field |
| ctrl_cmp | output | 2 | Compare mode field |
| wr_valid | output | 1 | Write strobe, one cycle, no ready |
| wr_data | output | 8 | Byte received in a write |

## Verification
The bench builds the block with DATA_W=8 and SYNC_STAGES=2, straps the address to 2'b10, and holds SCK for 8 system clocks per half period. This period leaves room for the synchroniser and edge-detect latency before each sample point. It also gives time to switch `cmp_flag` after the enable falls, which shows that the latched value and not the live one reaches the header's last slot. The random frames mix both idle levels, all four addresses, both registers and read or write frames of one to four bytes. Together they reach address mismatches, repeated reads and bytes that follow a write.

// File: rtl/spf_pkg.sv
package spf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_RDATA,
    ST_WDATA,
    ST_HOLD
  } spf_state_e;
endpackage

// File: rtl/spf_sync.sv
module spf_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= RST_VAL;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spf_edge.sv
module spf_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic cs_s,
  output logic start,
  output logic stop,
  output logic lead,
  output logic trail
);
  logic sck_d, cs_d, idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d  <= 1'b0;
      cs_d   <= 1'b1;
      idle_q <= 1'b0;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_s;
      if (start) idle_q <= sck_s;
    end
  end

  assign start = cs_d & ~cs_s;
  assign stop  = ~cs_d & cs_s;
  assign lead  = ~cs_s & ~start & (sck_d == idle_q) & (sck_s != idle_q);
  assign trail = ~cs_s & ~start & (sck_d != idle_q) & (sck_s == idle_q);
endmodule

// File: rtl/spf_frame.sv
module spf_frame
  import spf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic              lead,
  input  logic              trail,
  input  logic              mosi_s,
  input  logic [1:0]        id_strap,
  input  logic              cmp_flag,
  input  logic [DATA_W-1:0] rd_data,
  output logic              miso,
  output logic              miso_oe,
  output logic              rd_sel,
  output logic              ctrl_valid,
  output logic [DATA_W-3:0] ctrl_q,
  output logic              wr_valid,
  output logic [DATA_W-1:0] wr_data
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] ECHO_FIRST = CNT_W'(3);

  spf_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-2:0] rx_sr;
  logic [DATA_W-1:0] tx_sr;
  logic              flag_q, id_ok, miso_q, oe_q;

  // header bits: RS at DATA_W-3, RW at DATA_W-4; rx_sr lags by one bit at the last edge
  assign rd_sel  = (state == ST_HDR) ? rx_sr[DATA_W-4] : ctrl_q[DATA_W-3];
  assign miso    = miso_q;
  assign miso_oe = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      rx_sr      <= '0;
      tx_sr      <= '0;
      flag_q     <= 1'b0;
      id_ok      <= 1'b0;
      miso_q     <= 1'b0;
      oe_q       <= 1'b0;
      ctrl_q     <= '0;
      ctrl_valid <= 1'b0;
      wr_valid   <= 1'b0;
      wr_data    <= '0;
    end else begin
      ctrl_valid <= 1'b0;
      wr_valid   <= 1'b0;
      if (stop) begin
        state <= ST_IDLE;
        oe_q  <= 1'b0;
      end else if (start) begin
        state  <= ST_HDR;
        cnt    <= '0;
        flag_q <= cmp_flag;
        id_ok  <= 1'b0;
        oe_q   <= 1'b0;
      end else begin
        if (lead) begin
          unique case (state)
            ST_HDR: if (cnt >= ECHO_FIRST && id_ok) begin
              oe_q   <= 1'b1;
              miso_q <= (cnt == LAST) ? flag_q : rx_sr[2];
            end
            ST_RDATA, ST_WDATA: begin
              oe_q   <= 1'b1;
              miso_q <= tx_sr[DATA_W-1];
              tx_sr  <= {tx_sr[DATA_W-2:0], 1'b0};
            end
            default: ;
          endcase
        end
        if (trail) begin
          cnt   <= cnt + 1'b1;
          rx_sr <= {rx_sr[DATA_W-3:0], mosi_s};
          unique case (state)
            ST_HDR: begin
              if (cnt == CNT_W'(1)) id_ok <= ({rx_sr[0], mosi_s} == id_strap);
              if (cnt == LAST) begin
                if (!id_ok) begin
                  state <= ST_HOLD;
                end else begin
                  ctrl_q     <= {rx_sr[DATA_W-4:0], mosi_s};
                  ctrl_valid <= 1'b1;
                  tx_sr      <= rd_data;
                  state      <= rx_sr[DATA_W-5] ? ST_WDATA : ST_RDATA;
                end
              end
            end
            ST_RDATA: if (cnt == LAST) tx_sr <= rd_data;
            ST_WDATA: if (cnt == LAST) begin
              wr_valid <= 1'b1;
              wr_data  <= {rx_sr, mosi_s};
              state    <= ST_HOLD;
              oe_q     <= 1'b0;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/spf_port_ctrl.sv
module spf_port_ctrl #(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              mosi,
  input  logic [1:0]        id_strap,
  input  logic              cmp_flag,
  input  logic [DATA_W-1:0] rd_data,
  output logic              miso,
  output logic              miso_oe,
  output logic              rd_sel,
  output logic              ctrl_valid,
  output logic              ctrl_sel,
  output logic              ctrl_rw,
  output logic [1:0]        ctrl_fmt,
  output logic [1:0]        ctrl_cmp,
  output logic              wr_valid,
  output logic [DATA_W-1:0] wr_data
);
  logic [2:0] raw_in, syn_in;
  logic start, stop, lead, trail;
  logic [DATA_W-3:0] ctrl_q;

  assign raw_in = {cs_n, sck, mosi};

  spf_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  spf_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sck_s(syn_in[1]), .cs_s(syn_in[2]),
    .start(start), .stop(stop), .lead(lead), .trail(trail)
  );

  spf_frame #(.DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .lead(lead), .trail(trail), .mosi_s(syn_in[0]),
    .id_strap(id_strap), .cmp_flag(cmp_flag), .rd_data(rd_data),
    .miso(miso), .miso_oe(miso_oe), .rd_sel(rd_sel),
    .ctrl_valid(ctrl_valid), .ctrl_q(ctrl_q),
    .wr_valid(wr_valid), .wr_data(wr_data)
  );

  assign ctrl_sel = ctrl_q[DATA_W-3];
  assign ctrl_rw  = ctrl_q[DATA_W-4];
  assign ctrl_fmt = ctrl_q[3:2];
  assign ctrl_cmp = ctrl_q[1:0];
endmodule

// File: rtl/spf_port_ctrl_chk.sv
module spf_port_ctrl_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic miso_oe,
  input logic ctrl_valid,
  input logic ctrl_rw,
  input logic wr_valid
);
  localparam int HI_LIMIT = SYNC_STAGES + 2;

  logic [7:0] hi_cnt;
  logic       wr_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt  <= '0;
      wr_seen <= 1'b0;
    end else begin
      if (!cs_n)                  hi_cnt <= '0;
      else if (hi_cnt != 8'hFF)   hi_cnt <= hi_cnt + 1'b1;
      if (ctrl_valid)    wr_seen <= 1'b0;
      else if (wr_valid) wr_seen <= 1'b1;
    end
  end

  assert_idle_undriven_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && hi_cnt >= 8'(HI_LIMIT)) |-> !miso_oe);

  assert_hdr_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_valid |=> !ctrl_valid);

  assert_wr_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  assert_wr_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ctrl_rw);

  assert_one_write_per_hdr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !wr_seen);
endmodule

bind spf_port_ctrl spf_port_ctrl_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso_oe(miso_oe),
  .ctrl_valid(ctrl_valid), .ctrl_rw(ctrl_rw), .wr_valid(wr_valid)
);

// File: tb/spf_port_ctrl_tb.sv
module spf_port_ctrl_tb;
  localparam int H = 8;
  localparam logic [1:0] MY_ID = 2'b10;

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, mosi = 0, cmp_flag = 0;
  logic [1:0] id_strap = MY_ID;
  logic [7:0] rd_data, wr_data;
  logic miso, miso_oe, rd_sel, ctrl_valid, ctrl_sel, ctrl_rw, wr_valid;
  logic [1:0] ctrl_fmt, ctrl_cmp;

  int tests = 0, fails = 0;
  int wr_count = 0, cv_count = 0;
  logic [7:0] last_wr, last_hdr;
  logic [7:0] data_m = 8'h00, dir_m = 8'h00;
  logic [7:0] frame_tx [4];
  logic [7:0] cap_oe [4];
  logic [7:0] cap_v [4];

  always #10 clk = ~clk;

  spf_port_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .id_strap(id_strap), .cmp_flag(cmp_flag), .rd_data(rd_data),
    .miso(miso), .miso_oe(miso_oe), .rd_sel(rd_sel),
    .ctrl_valid(ctrl_valid), .ctrl_sel(ctrl_sel), .ctrl_rw(ctrl_rw),
    .ctrl_fmt(ctrl_fmt), .ctrl_cmp(ctrl_cmp),
    .wr_valid(wr_valid), .wr_data(wr_data)
  );

  // bench register file model
  assign rd_data = rd_sel ? dir_m : data_m;

  function automatic logic [7:0] apply_fmt(logic [7:0] old, logic [1:0] fmt, logic [7:0] d);
    if (!fmt[1])     return d;
    else if (fmt[0]) return old | d;
    else             return old & ~d;
  endfunction

  always @(posedge clk) begin
    if (wr_valid) begin
      wr_count <= wr_count + 1;
      last_wr  <= wr_data;
      if (ctrl_sel) dir_m  <= apply_fmt(dir_m, ctrl_fmt, wr_data);
      else          data_m <= apply_fmt(data_m, ctrl_fmt, wr_data);
    end
    if (ctrl_valid) cv_count <= cv_count + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input bit idle, input logic [7:0] hdr, input int nb, input bit flag);
    bit match = (hdr[7:6] == id_strap);
    logic [7:0] regv = hdr[5] ? dir_m : data_m;
    int wr0 = wr_count, cv0 = cv_count;
    frame_tx[0] = hdr;
    cmp_flag = flag; sck = idle; wclk(H);
    cs_n = 0; wclk(H);
    cmp_flag = ~flag;  // must not leak: flag is latched at the enable fall
    for (int b = 0; b < nb; b++) begin
      for (int k = 0; k < 8; k++) begin
        sck = ~idle; mosi = frame_tx[b][7-k]; wclk(H);
        cap_oe[b][7-k] = miso_oe; cap_v[b][7-k] = miso;
        sck = idle; wclk(H);
      end
    end
    wclk(H); cs_n = 1; wclk(6);
    chk(miso_oe == 1'b0, "R1", "oe after enable high", miso_oe, 0);
    for (int b = 0; b < nb; b++) begin
      logic [7:0] eo, ev;
      string tag;
      if (b == 0) begin
        eo = match ? 8'b0001_1111 : 8'h00;
        ev = {3'b000, hdr[7:4], flag};
        tag = idle ? "R2" : "R4";
      end else if (!match) begin
        eo = 8'h00; ev = 8'h00; tag = "R3";
      end else if (!hdr[4]) begin
        eo = 8'hFF; ev = regv; tag = (b == 1) ? "R6" : "R7";
      end else begin
        eo = (b == 1) ? 8'hFF : 8'h00; ev = regv; tag = (b == 1) ? "R8" : "R9";
      end
      chk((cap_oe[b] == eo) && ((cap_v[b] & eo) == (ev & eo)), tag,
          $sformatf("miso byte %0d", b), {cap_oe[b], cap_v[b]}, {eo, ev});
    end
    chk((cv_count - cv0) == (match ? 1 : 0), match ? "R5" : "R3", "header pulses",
        cv_count - cv0, match ? 1 : 0);
    if (match)
      chk({ctrl_sel, ctrl_rw, ctrl_fmt, ctrl_cmp} == hdr[5:0], "R5", "header fields",
          {ctrl_sel, ctrl_rw, ctrl_fmt, ctrl_cmp}, hdr[5:0]);
    begin
      int ew = (match && hdr[4] && nb >= 2) ? 1 : 0;
      chk((wr_count - wr0) == ew, (nb > 2) ? "R9" : "R8", "write strobes", wr_count - wr0, ew);
      if (ew == 1) chk(last_wr == frame_tx[1], "R8", "write data", last_wr, frame_tx[1]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    wclk(3);
    chk(miso_oe == 0 && wr_valid == 0 && ctrl_valid == 0, "R1", "reset state",
        {miso_oe, wr_valid, ctrl_valid}, 0);
    rst_n = 1; wclk(4);
    // directed: write data reg, idle low
    frame_tx[1] = 8'hA5; frame(1'b0, {MY_ID, 6'b0_1_00_11}, 2, 1'b1);
    chk(data_m == 8'hA5, "R8", "data reg after write", data_m, 8'hA5);
    // write direction reg with idle high, set-mask
    frame_tx[1] = 8'h0F; frame(1'b1, {MY_ID, 6'b1_1_11_01}, 2, 1'b0);
    chk(dir_m == 8'h0F, "R2", "dir reg after set mask", dir_m, 8'h0F);
    // repeated read of data reg
    frame_tx[1] = 8'h00; frame_tx[2] = 8'hFF; frame_tx[3] = 8'h3C;
    frame(1'b0, {MY_ID, 6'b0_0_10_10}, 4, 1'b1);
    // address mismatch must leave everything alone
    frame_tx[1] = 8'h11; frame(1'b0, {2'b01, 6'b0_1_00_00}, 2, 1'b0);
    chk(data_m == 8'hA5, "R3", "data reg after foreign write", data_m, 8'hA5);
    // extra bytes after a write
    frame_tx[1] = 8'h81; frame_tx[2] = 8'h7E; frame(1'b1, {MY_ID, 6'b0_1_10_00}, 3, 1'b1);
    chk(data_m == 8'h24, "R9", "clear mask applied once", data_m, 8'h24);
    // random frames
    for (int n = 0; n < 40; n++) begin
      logic [7:0] h = 8'($urandom);
      int nb = 1 + ($urandom % 4);
      if (($urandom % 4) != 0) h[7:6] = MY_ID;
      for (int b = 1; b < 4; b++) frame_tx[b] = 8'($urandom);
      frame(1'($urandom), h, nb, 1'($urandom));
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule